// File: doc/BRIEF.md
# DAC Update Controller with Double-Buffered Value

This block is the digital front end that decides which 12-bit code a converter receives and when that code changes. Software sees two value registers. The current value drives the converter. The next value waits until a transfer event copies it into the current value.

A three-bit update-mode field picks the transfer event. In direct mode, software writes the current value itself. In buffered mode, every pulse of an update-clock enable causes a transfer. In edge-armed mode, a rising strobe arms exactly one transfer, which happens on the following update pulse. In edge-immediate mode, every rising strobe causes a transfer. In level-gated mode, update pulses cause transfers only while the strobe is high.

Each transfer sets a sticky interrupt status bit and starts a two-cycle pulse intended for a DMA engine. Before the code reaches the converter, it is passed through an unsigned or offset-binary format. A range bit and an output-enable bit are sent alongside the code.

The strobe arrives from another clock domain. It crosses into the peripheral clock domain through a two-flop synchronizer followed by an edge detector. The update clock arrives as a one-cycle enable pulse that is already in the peripheral clock domain.

The controller contains two small state machines:
- **Arm machine** with states ARM_IDLE and ARM_WAIT. It takes the transition IDLE→WAIT on a synchronized rising strobe in edge-armed mode. It takes WAIT→IDLE when the transfer is consumed or the mode changes.
- **Trigger machine** with states TRG_IDLE, TRG_HOLD1 and TRG_HOLD2. Any state moves to HOLD1 on a transfer. HOLD1 moves to HOLD2, and HOLD2 moves to IDLE.

Top module: `dac_upd_ctrl`

Register map. Writes happen on the clock edge. Reads are combinational from `reg_addr`.

| Address | Register | Access |
|---|---|---|
| 0 | control: [2:0] update mode, [3] signed format, [4] range (plus one), [5] output enable | read/write |
| 1 | current value | read/write |
| 2 | next value | read/write |
| 3 | interrupt status | read; writing 1 in bit 0 clears it |
| 4 | interrupt set | write only; writing 1 in bit 0 sets the status |
| 5 | interrupt mask, bit 0 | read/write |
| 6 | masked status | read only |

## Requirements
- R1: After reset, every register reads 0, `dac_code` is 0, and `dac_oe`, `dac_plus1`, `irq` and `dma_trig` are all 0.
- R2: In update mode 0 (direct), a write to address 1 changes `dac_code` in the cycle after the write edge. Writes to address 2 and pulses on `upd_tick` change neither the current value nor the interrupt status, and they do not drive `dma_trig`.
- R3: In update mode 1 (buffered), the clock edge that samples `upd_tick` high copies the next value into the current value. The same edge sets the interrupt status.
- R4: `dma_trig` is high for exactly the two cycles that follow a transfer edge. A transfer that occurs while `dma_trig` is high restarts the two-cycle window.
- R5: In update mode 2 (edge-armed), an `upd_tick` pulse causes no transfer unless a synchronized rising strobe has armed one. One arming produces exactly one transfer, on the next `upd_tick`.
- R6: In update mode 3 (edge-immediate), a rising `strobe_in` causes a transfer on the third clock edge after the strobe goes high. `dac_code` is still the old value after the second edge.
- R7: In update mode 4 (level-gated), an `upd_tick` pulse causes a transfer only while the synchronized strobe is high.
- R8: Update modes 5, 6 and 7 cause no transfer from `upd_tick` or from the strobe.
- R9: When bit 3 of the control register (signed format) is 1, `dac_code` equals the current value plus 0x800, modulo 4096. When the bit is 0, `dac_code` equals the current value.
- R10: `dac_plus1` follows control bit 4, and `dac_oe` follows control bit 5.
- R11: The interrupt status is sticky. Writing 1 to address 3 clears it, and writing 1 to address 4 sets it. A set from a transfer wins over a clear written in the same cycle. `irq`, and the value read at address 6, equal the status ANDed with the mask.
- R12: A transfer copies the next value even if software has not rewritten it since the last transfer, and it still sets the interrupt status. A transfer wins over a software write to the current value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data (combinational) |
| upd_tick | input | 1 | Update-clock enable, one cycle long |
| strobe_in | input | 1 | Asynchronous external strobe |
| dac_code | output | 12 | Formatted code sent to the converter |
| dac_plus1 | output | 1 | Range request: the converter outputs the code plus one |
| dac_oe | output | 1 | Converter output enable; 0 means high impedance |
| irq | output | 1 | Masked interrupt |
| dma_trig | output | 1 | Two-cycle DMA trigger pulse |

## Verification
Two actions can land on the same clock edge: a transfer and a software write to the interrupt-clear register. A transfer and a software write to the current value can also coincide. The bench provokes each collision by asserting `upd_tick` and the register write in the same cycle. It then judges the outcome at the ports: the status bit read back must still be 1, and the code seen by the scoreboard must be the next value, not the written one. Two consecutive update pulses overlap the trigger windows, and the bench checks that `dma_trig` stays high through the extended window.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

    localparam int ADDR_W = 3;
    localparam int CTRL_W = 6;

    // Control field positions
    localparam int CTL_SIGNED = 3;
    localparam int CTL_RANGE  = 4;
    localparam int CTL_OE     = 5;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CUR   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_NXT   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_SET   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_MSTAT = 3'd6;

    typedef enum logic [2:0] {
        UPD_DIRECT    = 3'd0,
        UPD_BUFFERED  = 3'd1,
        UPD_EDGE_SYNC = 3'd2,
        UPD_EDGE_IMM  = 3'd3,
        UPD_LEVEL     = 3'd4
    } upd_mode_e;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_WAIT = 1'b1
    } arm_state_e;

    typedef enum logic [1:0] {
        TRG_IDLE  = 2'd0,
        TRG_HOLD1 = 2'd1,
        TRG_HOLD2 = 2'd2
    } trg_state_e;

endpackage

// File: rtl/dac_strobe_sync.sv
module dac_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic strobe_lvl,
    output logic strobe_rise
);
    // The shift register holds the synchronizer stages plus one extra flop
    // that supplies the previous level for edge detection.
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], strobe_async};
        end
    end

    assign strobe_lvl  = sh_q[STAGES-1];
    assign strobe_rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> !strobe_rise); // R6

endmodule

// File: rtl/dac_xfer_fsm.sv
module dac_xfer_fsm
    import dac_upd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       tick,
    input  logic       strobe_lvl,
    input  logic       strobe_rise,
    output logic       xfer,
    output logic       dma_trig
);
    arm_state_e arm_q, arm_d;
    trg_state_e trg_q, trg_d;
    logic       edge_sync_mode;

    assign edge_sync_mode = (mode == UPD_EDGE_SYNC);

    // Arm machine: next state
    always_comb begin
        arm_d = arm_q;
        unique case (arm_q)
            ARM_IDLE: begin
                if (edge_sync_mode && strobe_rise) begin
                    arm_d = ARM_WAIT;
                end
            end
            ARM_WAIT: begin
                if (!edge_sync_mode) begin
                    arm_d = ARM_IDLE;
                end else if (tick && !strobe_rise) begin
                    arm_d = ARM_IDLE;
                end
            end
            default: arm_d = ARM_IDLE;
        endcase
    end

    // Trigger machine: next state
    always_comb begin
        trg_d = trg_q;
        if (xfer) begin
            trg_d = TRG_HOLD1;
        end else begin
            unique case (trg_q)
                TRG_IDLE:  trg_d = TRG_IDLE;
                TRG_HOLD1: trg_d = TRG_HOLD2;
                TRG_HOLD2: trg_d = TRG_IDLE;
                default:   trg_d = TRG_IDLE;
            endcase
        end
    end

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= ARM_IDLE;
            trg_q <= TRG_IDLE;
        end else begin
            arm_q <= arm_d;
            trg_q <= trg_d;
        end
    end

    // Outputs: transfer decode by update mode, trigger from state
    always_comb begin
        xfer = 1'b0;
        unique case (mode)
            UPD_DIRECT:    xfer = 1'b0;
            UPD_BUFFERED:  xfer = tick;
            UPD_EDGE_SYNC: xfer = tick && (arm_q == ARM_WAIT);
            UPD_EDGE_IMM:  xfer = strobe_rise;
            UPD_LEVEL:     xfer = tick && strobe_lvl;
            default:       xfer = 1'b0;
        endcase
        dma_trig = (trg_q != TRG_IDLE);
    end

    AST_TRIG_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_trig) |=> dma_trig); // R4

    AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && edge_sync_mode && !strobe_rise) |=> (arm_q == ARM_IDLE)); // R5

endmodule

// File: rtl/dac_code_fmt.sv
module dac_code_fmt #(
    parameter int DAC_W = 12
) (
    input  logic [DAC_W-1:0] value,
    input  logic             signed_fmt,
    output logic [DAC_W-1:0] code
);
    localparam logic [DAC_W-1:0] HALF = DAC_W'(1) << (DAC_W - 1);

    always_comb begin
        if (signed_fmt) begin
            code = value + HALF;   // wraps modulo 2**DAC_W
        end else begin
            code = value;
        end
    end

endmodule

// File: rtl/dac_upd_ctrl.sv
module dac_upd_ctrl
    import dac_upd_pkg::*;
#(
    parameter int DAC_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [DAC_W-1:0] reg_wdata,
    output logic [DAC_W-1:0] reg_rdata,
    input  logic             upd_tick,
    input  logic             strobe_in,
    output logic [DAC_W-1:0] dac_code,
    output logic             dac_plus1,
    output logic             dac_oe,
    output logic             irq,
    output logic             dma_trig
);
    localparam int PAD_CTRL = DAC_W - CTRL_W;
    localparam int PAD_BIT  = DAC_W - 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DAC_W-1:0]  cur_q;
    logic [DAC_W-1:0]  nxt_q;
    logic              irq_stat_q;
    logic              irq_mask_q;

    logic strobe_lvl;
    logic strobe_rise;
    logic xfer;

    logic wr_ctrl, wr_cur, wr_nxt, wr_clr, wr_set, wr_mask;

    assign wr_ctrl = reg_we && (reg_addr == ADR_CTRL);
    assign wr_cur  = reg_we && (reg_addr == ADR_CUR);
    assign wr_nxt  = reg_we && (reg_addr == ADR_NXT);
    assign wr_clr  = reg_we && (reg_addr == ADR_STAT) && reg_wdata[0];
    assign wr_set  = reg_we && (reg_addr == ADR_SET)  && reg_wdata[0];
    assign wr_mask = reg_we && (reg_addr == ADR_MASK);

    dac_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (strobe_in),
        .strobe_lvl   (strobe_lvl),
        .strobe_rise  (strobe_rise)
    );

    dac_xfer_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (ctrl_q[2:0]),
        .tick        (upd_tick),
        .strobe_lvl  (strobe_lvl),
        .strobe_rise (strobe_rise),
        .xfer        (xfer),
        .dma_trig    (dma_trig)
    );

    dac_code_fmt #(.DAC_W(DAC_W)) u_fmt (
        .value      (cur_q),
        .signed_fmt (ctrl_q[CTL_SIGNED]),
        .code       (dac_code)
    );

    // Register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            cur_q      <= '0;
            nxt_q      <= '0;
            irq_stat_q <= 1'b0;
            irq_mask_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= reg_wdata[CTRL_W-1:0];
            end
            // A transfer takes precedence over a direct write
            if (xfer) begin
                cur_q <= nxt_q;
            end else if (wr_cur) begin
                cur_q <= reg_wdata;
            end
            if (wr_nxt) begin
                nxt_q <= reg_wdata;
            end
            // A set takes precedence over a clear
            if (xfer || wr_set) begin
                irq_stat_q <= 1'b1;
            end else if (wr_clr) begin
                irq_stat_q <= 1'b0;
            end
            if (wr_mask) begin
                irq_mask_q <= reg_wdata[0];
            end
        end
    end

    // Read mux
    always_comb begin
        unique case (reg_addr)
            ADR_CTRL:  reg_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
            ADR_CUR:   reg_rdata = cur_q;
            ADR_NXT:   reg_rdata = nxt_q;
            ADR_STAT:  reg_rdata = {{PAD_BIT{1'b0}}, irq_stat_q};
            ADR_MASK:  reg_rdata = {{PAD_BIT{1'b0}}, irq_mask_q};
            ADR_MSTAT: reg_rdata = {{PAD_BIT{1'b0}}, irq_stat_q & irq_mask_q};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq       = irq_stat_q & irq_mask_q;
    assign dac_plus1 = ctrl_q[CTL_RANGE];
    assign dac_oe    = ctrl_q[CTL_OE];

    AST_XFER_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (cur_q == $past(nxt_q))); // R3

    AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q[2:0] == UPD_DIRECT) && !irq_stat_q && !wr_set) |=> !irq_stat_q); // R2

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat_q && !wr_clr) |=> irq_stat_q); // R11

    AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q[2:0] > 3'd4) && !wr_cur) |=> $stable(cur_q)); // R8

endmodule

// File: tb/dac_upd_ctrl_tb_top.sv
module dac_upd_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [11:0] reg_wdata = '0;
    logic [11:0] reg_rdata;
    logic        upd_tick = 1'b0;
    logic        strobe_in = 1'b0;
    logic [11:0] dac_code;
    logic        dac_plus1, dac_oe, irq, dma_trig;

    int n_checks = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [11:0] exp_q[$];
    logic [11:0] last_code = '0;

    always #10 clk = ~clk;   // 50 MHz

    dac_upd_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .upd_tick  (upd_tick),
        .strobe_in (strobe_in),
        .dac_code  (dac_code),
        .dac_plus1 (dac_plus1),
        .dac_oe    (dac_oe),
        .irq       (irq),
        .dma_trig  (dma_trig)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [11:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        upd_tick = 1'b1;
        @(negedge clk);
        upd_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor: every change of dac_code must match the next queued item
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done && dac_code !== last_code) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL scoreboard: actual=%0h expected=<none>", dac_code);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    if (dac_code !== e) begin
                        n_bad++;
                        $display("FAIL scoreboard: actual=%0h expected=%0h", dac_code, e);
                    end
                end
                last_code = dac_code;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] r;
        idle(3);
        // R1 reset state
        check("R1 code", dac_code, 0);
        check("R1 outs", {dac_oe, dac_plus1, irq, dma_trig}, 0);
        rst_n = 1'b1;
        idle(2);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), r);
            check("R1 reg", r, 0);
        end

        // R10 output enable
        wr(3'd0, 12'h020);
        check("R10 oe", dac_oe, 1);

        // R2 direct mode
        exp_q.push_back(12'h5A5);
        wr(3'd1, 12'h5A5);
        check("R2 code after write", dac_code, 12'h5A5);
        wr(3'd2, 12'h111);
        tick(); tick();
        check("R2 no trig", dma_trig, 0);
        rd(3'd3, r); check("R2 no irq status", r, 0);
        rd(3'd1, r); check("R2 cur kept", r, 12'h5A5);

        // R3 / R4 buffered mode
        wr(3'd0, 12'h021);
        exp_q.push_back(12'h111);
        tick();
        check("R3 code", dac_code, 12'h111);
        check("R4 trig c1", dma_trig, 1);
        rd(3'd3, r); check("R3 status", r, 1);
        check("R4 trig c2", dma_trig, 1);
        idle(1);
        check("R4 trig off", dma_trig, 0);
        check("R11 irq masked off", irq, 0);
        wr(3'd5, 12'h001);
        check("R11 irq", irq, 1);
        rd(3'd6, r); check("R11 masked read", r, 1);

        // R11 clear/set
        wr(3'd3, 12'h001);
        check("R11 clear", irq, 0);
        wr(3'd4, 12'h001);
        check("R11 set", irq, 1);
        wr(3'd3, 12'h001);

        // R12 repeat transfer without rewrite
        tick();
        check("R12 repeat irq", irq, 1);
        check("R12 repeat code", dac_code, 12'h111);
        wr(3'd3, 12'h001);

        // R11 set wins over clear in same cycle
        wr(3'd2, 12'h222);
        exp_q.push_back(12'h222);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 12'h001; upd_tick = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; upd_tick = 1'b0;
        check("R11 set beats clear", irq, 1);
        wr(3'd3, 12'h001);

        // R12 transfer beats direct write
        wr(3'd2, 12'h333);
        exp_q.push_back(12'h333);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 12'h777; upd_tick = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; upd_tick = 1'b0;
        check("R12 xfer beats write", dac_code, 12'h333);
        idle(3);

        // R4 back-to-back restart
        @(negedge clk); upd_tick = 1'b1;
        idle(2); upd_tick = 1'b0;
        check("R4 restart a", dma_trig, 1);
        idle(1); check("R4 restart b", dma_trig, 1);
        idle(1); check("R4 restart end", dma_trig, 0);

        // R5 edge-armed
        wr(3'd0, 12'h022);
        wr(3'd3, 12'h001);
        wr(3'd2, 12'h444);
        tick();
        rd(3'd3, r); check("R5 unarmed no xfer", r, 0);
        exp_q.push_back(12'h444);
        @(negedge clk); strobe_in = 1'b1;
        idle(4); strobe_in = 1'b0;
        check("R5 armed waits for tick", dac_code, 12'h333);
        tick();
        check("R5 armed xfer", dac_code, 12'h444);
        wr(3'd3, 12'h001);
        wr(3'd2, 12'h555);
        tick();
        rd(3'd3, r); check("R5 one per arm", r, 0);
        idle(3);

        // R6 edge-immediate
        wr(3'd0, 12'h023);
        wr(3'd2, 12'h666);
        exp_q.push_back(12'h666);
        @(negedge clk); strobe_in = 1'b1;
        idle(2);
        check("R6 not yet", dac_code, 12'h444);
        idle(1);
        check("R6 third edge", dac_code, 12'h666);
        strobe_in = 1'b0;
        idle(4);

        // R7 level-gated
        wr(3'd0, 12'h024);
        wr(3'd3, 12'h001);
        wr(3'd2, 12'h777);
        tick();
        rd(3'd3, r); check("R7 low strobe no xfer", r, 0);
        exp_q.push_back(12'h777);
        @(negedge clk); strobe_in = 1'b1;
        idle(3);
        tick();
        check("R7 high strobe xfer", dac_code, 12'h777);
        strobe_in = 1'b0;
        idle(4);

        // R8 invalid modes
        wr(3'd3, 12'h001);
        wr(3'd0, 12'h025);
        wr(3'd2, 12'h888);
        tick();
        @(negedge clk); strobe_in = 1'b1;
        idle(4); strobe_in = 1'b0;
        wr(3'd0, 12'h027);
        tick();
        idle(2);
        check("R8 code held", dac_code, 12'h777);
        rd(3'd3, r); check("R8 no status", r, 0);

        // R9 signed format, R10 range and oe
        exp_q.push_back(12'hF77);
        wr(3'd0, 12'h028);
        check("R9 signed", dac_code, 12'hF77);
        exp_q.push_back(12'h100);
        wr(3'd1, 12'h900);
        check("R9 wrap", dac_code, 12'h100);
        wr(3'd0, 12'h038);
        check("R10 plus1", dac_plus1, 1);
        wr(3'd0, 12'h018);
        check("R10 oe off", dac_oe, 0);
        idle(2);

        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule